// File: doc/BRIEF.md
# Character Memory Bank Translator

This block sits between the picture processor's pattern-table fetch port and the character memory. It turns a 14-bit pattern address into a byte address for a character ROM of configurable size, using six bank numbers that another part of the chip writes from the processor side. The 8 KB pattern space is split unevenly. The lower 4 KB is served by two 2 KB windows. The upper 4 KB is served by four 1 KB windows.

A build parameter picks the memory kind. With ROM, the bank numbers steer every access and writes never reach memory. With an 8 KB RAM, banking is bypassed: the low 13 address bits index the RAM directly, and writes inside the pattern space raise a write enable. Accesses that carry no strobe, or that fall outside the pattern space, are not claimed.

Each access is registered once. The result appears on the outputs one clock after the strobe.

Top module: `chr_bank_xlat`

## Requirements
- R1: An access to 0x0000-0x07FF produces address `(bank_lo_a mod C2) * 2048 + (addr & 0x7FF)`. C2 = 2^(ROM_AW-11) is the 2 KB bank count.
- R2: An access to 0x0800-0x0FFF produces the same form, using `bank_lo_b`.
- R3: Accesses to 0x1000-0x13FF, 0x1400-0x17FF, 0x1800-0x1BFF and 0x1C00-0x1FFF use `bank_hi_a`, `bank_hi_b`, `bank_hi_c` and `bank_hi_d` in that order. Each produces `(bank mod C1) * 1024 + (addr & 0x3FF)`, where C1 = 2^(ROM_AW-10) is the 1 KB bank count.
- R4: Bank numbers larger than the bank count wrap modulo that count. The final address never exceeds 2^ROM_AW - 1.
- R5: With USE_RAM = 1, the address is `addr & 0x1FFF`. No bank value affects it.
- R6: A write (`ppu_wr` = 1) anywhere in 0x0000-0x1FFF is claimed (`handled` = 1). It raises `ram_we` only when USE_RAM = 1. With ROM, `ram_we` stays 0.
- R7: An access with address bit 13 set (0x2000-0x3FFF) gives `handled` = 0 and `ram_we` = 0.
- R8: Outputs reflect the access strobed one clock earlier. A cycle with neither `ppu_rd` nor `ppu_wr` gives `handled` = 0 and `ram_we` = 0 one clock later.
- R9: While reset is held, and until it has been released through two clock edges, `mem_addr`, `ram_we` and `handled` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ppu_addr | input | 14 | Pattern fetch address |
| ppu_rd | input | 1 | Read strobe |
| ppu_wr | input | 1 | Write strobe |
| bank_lo_a | input | 8 | 2 KB bank for 0x0000-0x07FF |
| bank_lo_b | input | 8 | 2 KB bank for 0x0800-0x0FFF |
| bank_hi_a | input | 8 | 1 KB bank for 0x1000-0x13FF |
| bank_hi_b | input | 8 | 1 KB bank for 0x1400-0x17FF |
| bank_hi_c | input | 8 | 1 KB bank for 0x1800-0x1BFF |
| bank_hi_d | input | 8 | 1 KB bank for 0x1C00-0x1FFF |
| mem_addr | output | ROM_AW | Character memory byte address |
| ram_we | output | 1 | RAM write enable |
| handled | output | 1 | Access claimed by this block |

## Verification
The collision of interest is a bank number changing in the same cycle as an access that uses it. The translation must follow the value present in that cycle, not a stale one. The bench drives a new bank value and a strobe on the same falling edge. The expected address is computed from the new value, so a design that lags by a cycle misses the scoreboard entry. Accesses with read and write raised together are also driven. On the RAM instance they must both claim the access and raise the write enable.

// File: rtl/chr_xlat_pkg.sv
package chr_xlat_pkg;
  localparam int PPU_AW      = 14;
  localparam int BANK_W      = 8;
  localparam int NUM_SLOTS   = 6;
  localparam int SLOT_W      = $clog2(NUM_SLOTS);
  localparam int WIDE_SHIFT  = 11;
  localparam int NARROW_SHIFT = 10;
  localparam int RAM_AW      = 13;

  typedef logic [BANK_W-1:0] bank_t;

  typedef struct packed {
    logic              in_range;
    logic              wide;
    logic [SLOT_W-1:0] slot;
  } window_t;
endpackage

// File: rtl/chr_window_decode.sv
module chr_window_decode
  import chr_xlat_pkg::*;
(
  input  logic [PPU_AW-1:0] addr,
  output window_t           win
);
  always_comb begin
    win.in_range = ~addr[13];
    win.wide     = ~addr[12];
    if (~addr[12]) begin
      win.slot = SLOT_W'(addr[11]);
    end else begin
      win.slot = SLOT_W'(2) + SLOT_W'(addr[11:10]);
    end
  end
endmodule

// File: rtl/chr_bank_mux.sv
module chr_bank_mux
  import chr_xlat_pkg::*;
(
  input  bank_t             banks [NUM_SLOTS],
  input  logic [SLOT_W-1:0] slot,
  output bank_t             bank
);
  always_comb begin
    bank = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot == SLOT_W'(i)) bank = banks[i];
    end
  end
endmodule

// File: rtl/chr_addr_compose.sv
module chr_addr_compose
  import chr_xlat_pkg::*;
#(
  parameter int ROM_AW  = 17,
  parameter bit USE_RAM = 1'b0
) (
  input  logic [PPU_AW-1:0] addr,
  input  logic              wide,
  input  bank_t             bank,
  output logic [ROM_AW-1:0] mem_addr
);
  localparam int WIDE_BITS   = ROM_AW - WIDE_SHIFT;
  localparam int NARROW_BITS = ROM_AW - NARROW_SHIFT;
  localparam logic [ROM_AW-1:0] WIDE_MASK   = ROM_AW'((64'd1 << WIDE_BITS) - 64'd1);
  localparam logic [ROM_AW-1:0] NARROW_MASK = ROM_AW'((64'd1 << NARROW_BITS) - 64'd1);

  generate
    if (USE_RAM) begin : g_ram
      assign mem_addr = ROM_AW'(addr[RAM_AW-1:0]);
    end else begin : g_rom
      logic [ROM_AW-1:0] bank_ext;
      logic [ROM_AW-1:0] base;
      logic [ROM_AW-1:0] offset;
      always_comb begin
        bank_ext = ROM_AW'(bank);
        if (wide) begin
          base   = (bank_ext & WIDE_MASK) << WIDE_SHIFT;
          offset = ROM_AW'(addr[WIDE_SHIFT-1:0]);
        end else begin
          base   = (bank_ext & NARROW_MASK) << NARROW_SHIFT;
          offset = ROM_AW'(addr[NARROW_SHIFT-1:0]);
        end
        mem_addr = base + offset;
      end
    end
  endgenerate
endmodule

// File: rtl/chr_bank_xlat.sv
module chr_bank_xlat
  import chr_xlat_pkg::*;
#(
  parameter int ROM_AW  = 17,
  parameter bit USE_RAM = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [13:0]       ppu_addr,
  input  logic              ppu_rd,
  input  logic              ppu_wr,
  input  logic [7:0]        bank_lo_a,
  input  logic [7:0]        bank_lo_b,
  input  logic [7:0]        bank_hi_a,
  input  logic [7:0]        bank_hi_b,
  input  logic [7:0]        bank_hi_c,
  input  logic [7:0]        bank_hi_d,
  output logic [ROM_AW-1:0] mem_addr,
  output logic              ram_we,
  output logic              handled
);
  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  bank_t   banks [NUM_SLOTS];
  window_t win;
  bank_t   sel_bank;
  logic [ROM_AW-1:0] addr_c;

  assign banks[0] = bank_lo_a;
  assign banks[1] = bank_lo_b;
  assign banks[2] = bank_hi_a;
  assign banks[3] = bank_hi_b;
  assign banks[4] = bank_hi_c;
  assign banks[5] = bank_hi_d;

  chr_window_decode u_dec (.addr(ppu_addr), .win(win));
  chr_bank_mux u_mux (.banks(banks), .slot(win.slot), .bank(sel_bank));
  chr_addr_compose #(.ROM_AW(ROM_AW), .USE_RAM(USE_RAM)) u_cmp (
    .addr(ppu_addr), .wide(win.wide), .bank(sel_bank), .mem_addr(addr_c)
  );

  // next state
  logic strobe, hit, handled_d, we_d, addr_en;
  always_comb begin
    strobe    = ppu_rd | ppu_wr;
    hit       = strobe & win.in_range;
    handled_d = hit;
    we_d      = USE_RAM & hit & ppu_wr;
    addr_en   = hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      handled <= 1'b0;
      ram_we  <= 1'b0;
    end else begin
      handled <= handled_d;
      ram_we  <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  mem_addr <= '0;
    else if (addr_en) mem_addr <= addr_c;
  end

  assert_claim_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    handled |-> $past(ppu_rd | ppu_wr));
  assert_outside_ignored_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((ppu_rd | ppu_wr) && ppu_addr[13]) |=> (!handled && !ram_we));
  assert_we_claimed_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    ram_we |-> (handled && $past(ppu_wr)));
  assert_low_offset_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((ppu_rd | ppu_wr) && !ppu_addr[13]) |=> (mem_addr[9:0] == $past(ppu_addr[9:0])));

  generate
    if (USE_RAM) begin : g_ram_chk
      assert_ram_direct_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
        ((ppu_rd | ppu_wr) && !ppu_addr[13]) |=>
          (mem_addr == ROM_AW'($past(ppu_addr[12:0]))));
    end
  endgenerate
endmodule

// File: tb/chr_bank_xlat_tb.sv
`timescale 1ns/1ps
module chr_bank_xlat_tb;
  localparam int AW_R = 14;
  localparam int AW_M = 13;
  localparam int C2 = 1 << (AW_R - 11);
  localparam int C1 = 1 << (AW_R - 10);

  logic clk = 1'b0;
  logic rst_n;
  logic [13:0] addr;
  logic rd, wr;
  logic [7:0] bk [6];
  logic [AW_R-1:0] rom_addr;
  logic rom_we, rom_hd;
  logic [AW_M-1:0] ram_addr;
  logic ram_we, ram_hd;

  always #5 clk = ~clk;

  chr_bank_xlat #(.ROM_AW(AW_R), .USE_RAM(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ppu_addr(addr), .ppu_rd(rd), .ppu_wr(wr),
    .bank_lo_a(bk[0]), .bank_lo_b(bk[1]), .bank_hi_a(bk[2]), .bank_hi_b(bk[3]),
    .bank_hi_c(bk[4]), .bank_hi_d(bk[5]),
    .mem_addr(rom_addr), .ram_we(rom_we), .handled(rom_hd));

  chr_bank_xlat #(.ROM_AW(AW_M), .USE_RAM(1'b1)) u_dut_ram (
    .clk(clk), .rst_n(rst_n), .ppu_addr(addr), .ppu_rd(rd), .ppu_wr(wr),
    .bank_lo_a(bk[0]), .bank_lo_b(bk[1]), .bank_hi_a(bk[2]), .bank_hi_b(bk[3]),
    .bank_hi_c(bk[4]), .bank_hi_d(bk[5]),
    .mem_addr(ram_addr), .ram_we(ram_we), .handled(ram_hd));

  typedef struct {
    string tag;
    int    hd;
    int    rom_a;
    int    ram_a;
    int    ram_w;
  } exp_t;
  exp_t sbq [$];

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int rom_model(input int a);
    int b;
    if (a < 'h1000) begin
      b = bk[(a >> 11) & 1];
      return ((b % C2) * 2048 + (a & 'h7FF)) % (1 << AW_R);
    end
    b = bk[2 + ((a >> 10) & 3)];
    return ((b % C1) * 1024 + (a & 'h3FF)) % (1 << AW_R);
  endfunction

  // driver: applies one cycle of stimulus and pushes its expectation
  task automatic access(input int a, input bit r, input bit w, input string tag);
    exp_t e;
    @(negedge clk);
    addr = 14'(a); rd = r; wr = w;
    e.tag   = tag;
    e.hd    = ((r | w) && a < 'h2000) ? 1 : 0;
    e.rom_a = rom_model(a);
    e.ram_a = a & 'h1FFF;
    e.ram_w = (w && a < 'h2000) ? 1 : 0;
    sbq.push_back(e);
  endtask

  // monitor: compares registered outputs just after the edge that captured them
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() != 0) begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, "rom handled", int'(rom_hd), e.hd);
        chk(e.tag, "ram handled", int'(ram_hd), e.hd);
        chk(e.tag, "rom we (R6)", int'(rom_we), 0);
        chk(e.tag, "ram we", int'(ram_we), e.ram_w);
        if (e.hd != 0) begin
          chk(e.tag, "rom addr", int'(rom_addr), e.rom_a);
          chk(e.tag, "ram addr", int'(ram_addr), e.ram_a);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; rd = 1'b0; wr = 1'b0;
    bk[0] = 8'h05; bk[1] = 8'h02; bk[2] = 8'h03;
    bk[3] = 8'h0A; bk[4] = 8'h07; bk[5] = 8'h0F;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset rom addr", int'(rom_addr), 0);
    chk("R9", "reset handled", int'(rom_hd) + int'(ram_hd), 0);
    chk("R9", "reset we", int'(rom_we) + int'(ram_we), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R9", "one edge after release", int'(rom_hd) + int'(ram_we), 0);
    repeat (3) @(posedge clk);

    access('h0000, 1, 0, "R1 low edge");
    access('h07FF, 1, 0, "R1 high edge");
    access('h0800, 1, 0, "R2 low edge");
    access('h0FFF, 1, 0, "R2 high edge");
    access('h1000, 1, 0, "R3 slot a");
    access('h17FF, 1, 0, "R3 slot b");
    access('h1800, 1, 0, "R3 slot c");
    access('h1FFF, 1, 0, "R3 slot d");
    access('h0123, 0, 0, "R8 idle");
    access('h2000, 1, 0, "R7 lower bound");
    access('h3FFF, 0, 1, "R7 write outside");
    access('h0456, 0, 1, "R6 write low");
    access('h1ABC, 1, 1, "R6 read+write");
    access('h1FFF, 0, 0, "R8 idle after write");

    // bank values above the counts
    bk[0] = 8'hFF; bk[1] = 8'h8B; bk[2] = 8'h1F;
    bk[3] = 8'hF0; bk[4] = 8'h2D; bk[5] = 8'h80;
    for (int a = 'h0155; a < 'h2000; a += 'h0400) access(a, 1, 0, "R4 wrap");
    access('h1E33, 0, 1, "R5 regs ignored");

    // bank change in the same cycle as an access using it
    @(negedge clk);
    bk[1] = 8'h06;
    addr = 14'h0A5A; rd = 1'b1; wr = 1'b0;
    begin
      exp_t e;
      e.tag = "R2 same-cycle bank change";
      e.hd = 1; e.rom_a = rom_model('h0A5A); e.ram_a = 'h0A5A; e.ram_w = 0;
      sbq.push_back(e);
    end
    access('h0000, 0, 0, "R8 trailing idle");

    wait (sbq.size() == 0);
    @(posedge clk); #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule